// File: doc/BRIEF.md
# Host Bridge Address Window Decoder

This block sits between a 32-bit processor bus and a PCI-style backend. Each processor access is classified into a window: direct configuration, I/O, the configuration index/data port pair, interrupt acknowledge, memory, or unmapped. For a legal access it issues one registered backend request. The request carries the window code and the translated backend address. It also carries the written bytes placed on little-endian byte lanes.

Configuration cycles in the direct window take their device number from a one-hot select field. The lowest set bit of that field wins. The I/O window has two maps, chosen by a mode input. The contiguous map keeps a 64 KB port space. The sparse map gathers scattered address bits into a compact port number. The mode input is registered, so a change applies to accesses from the following cycle on.

Top module: `host_window_decoder`

## Requirements
- R1: Windows are chosen in this priority order, with window codes on `bkWindow`. Address 0xBFFF_FFF0 is interrupt acknowledge (4). 0x8080_0000..0x80BF_FFFF is direct configuration (2). Addresses at or above 0xC000_0000 are memory (5). 0x8000_0000..0xBFFF_FFFF is I/O (1), or configuration port (3) as set out in R6. Addresses below 0x8000_0000 are unmapped (0).
- R2: In the direct configuration window, the device index is the position k (0..10) of the lowest set address bit among bits 11..21, with k = 0 for bit 11. `bkAddr` is then {k, cpuAddr[10:0]}: k sits in bits 14:11 and all higher bits are zero.
- R3: A direct configuration access with none of address bits 11..21 set uses device index 11.
- R4: With the registered mode at 0 (contiguous), the I/O port is bits 15:0 of the offset from 0x8000_0000.
- R5: With the registered mode at 1 (sparse), the I/O port is offset bits 26:12 placed at port bits 19:5, with offset bits 4:0 kept as port bits 4:0.
- R6: I/O requests leave with `bkAddr` = 0x8000_0000 + port. A port in 0xCF8..0xCFF is reported as window 3 instead of 1.
- R7: `sparseMode` is sampled into a register on every clock. An access presented in the same cycle as a mode change still uses the old mode. The next access uses the new mode.
- R8: Lanes span 8 bytes. `bkLanes` holds size-many consecutive ones, starting at lane cpuAddr[1:0]. On writes, byte b of `cpuWdata` appears at lane cpuAddr[1:0]+b of `bkData`, so unaligned spans are allowed. Reads and unused lanes carry zero data.
- R9: An access is refused when its size is not 1, 2 or 4, when its address is unmapped, or when it is an interrupt acknowledge wider than one byte. A refused access pulses `bkError` one cycle later and raises no `bkValid`.
- R10: Each presented access gives exactly one `bkValid` or `bkError` pulse one clock later. Idle cycles give neither. After reset both are low.
- R11: Memory requests carry `bkAddr` = cpuAddr − 0xC000_0000. Interrupt acknowledge carries `bkAddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Access present this cycle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Processor byte address |
| cpuSize | input | 3 | Access size in bytes |
| cpuWdata | input | 32 | Write data, little-endian packed |
| sparseMode | input | 1 | I/O map select: 0 contiguous, 1 sparse |
| bkValid | output | 1 | Backend request strobe |
| bkWrite | output | 1 | Request is a write |
| bkError | output | 1 | Access refused |
| bkWindow | output | 3 | Window code |
| bkAddr | output | 32 | Translated backend address |
| bkLanes | output | 8 | Active byte lanes |
| bkData | output | 64 | Lane-aligned write data |

## Verification
The bench sends several device-select patterns at the configuration window. One has a single bit, one has several bits (only the lowest may win), one has the top bit, and one has none. A priority encoder that favoured the highest bit, or that defaulted to zero, would give the wrong device field. The mode is changed in the same cycle as an access and then again before the next one. A decoder that used the mode without its register would switch one access early. Other cases are the 0xCF7/0xCF8/0xCFC port edges, an unaligned halfword at offset 3 that crosses into the upper lanes, a wide interrupt acknowledge, a size of 3, and an unmapped address. Each of these shows up as a wrong window code, a wrong lane shift, or a missing error pulse.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

  typedef enum logic [2:0] {
    WIN_NONE    = 3'd0,
    WIN_IO      = 3'd1,
    WIN_CFG     = 3'd2,
    WIN_CFGPORT = 3'd3,
    WIN_INTACK  = 3'd4,
    WIN_MEM     = 3'd5
  } win_e;

  typedef struct packed {
    logic issue;
    logic write;
    logic fault;
    win_e win;
  } strobe_t;

endpackage

// File: rtl/hbw_io_map.sv
module hbw_io_map #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'h8000_0000,
  parameter int unsigned CONTIG_W = 16,
  parameter int unsigned SP_LO_W = 5,
  parameter int unsigned SP_HI_LSB = 12,
  parameter int unsigned SP_HI_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sparseMode,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [ADDR_W-1:0] ioPort
);

  localparam logic [ADDR_W-1:0] CONTIG_MASK = {ADDR_W{1'b1}} >> (ADDR_W - CONTIG_W);
  localparam logic [ADDR_W-1:0] LO_MASK     = {ADDR_W{1'b1}} >> (ADDR_W - SP_LO_W);
  localparam logic [ADDR_W-1:0] HI_MASK     = {ADDR_W{1'b1}} >> (ADDR_W - SP_HI_W);

  logic              modeQ;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] contigPort;
  logic [ADDR_W-1:0] sparsePort;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= sparseMode;
  end

  always_comb begin
    offset     = cpuAddr - IO_BASE;
    contigPort = offset & CONTIG_MASK;
    sparsePort = (((offset >> SP_HI_LSB) & HI_MASK) << SP_LO_W) | (offset & LO_MASK);
    ioPort     = modeQ ? sparsePort : contigPort;
  end

endmodule

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
  import hbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h8080_0000,
  parameter int unsigned CFG_SPAN_LG = 22,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] MEM_BASE = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] INTACK_ADDR = 32'hBFFF_FFF0,
  parameter logic [ADDR_W-1:0] CFGPORT_BASE = 32'h0000_0CF8,
  parameter int unsigned CFGPORT_LG = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [2:0]        cpuSize,
  input  logic [ADDR_W-1:0] ioPort,
  output strobe_t           stNow,
  output strobe_t           stReg
);

  win_e win;
  logic sizeOk;
  logic allowed;

  always_comb begin
    win = WIN_NONE;
    if (cpuAddr == INTACK_ADDR) begin
      win = WIN_INTACK;
    end else if ((cpuAddr >> CFG_SPAN_LG) == (CFG_BASE >> CFG_SPAN_LG)) begin
      win = WIN_CFG;
    end else if (cpuAddr >= MEM_BASE) begin
      win = WIN_MEM;
    end else if (cpuAddr >= IO_BASE) begin
      win = ((ioPort >> CFGPORT_LG) == (CFGPORT_BASE >> CFGPORT_LG)) ? WIN_CFGPORT : WIN_IO;
    end
    sizeOk  = (cpuSize == 3'd1) || (cpuSize == 3'd2) || (cpuSize == 3'd4);
    allowed = sizeOk && (win != WIN_NONE) && !((win == WIN_INTACK) && (cpuSize != 3'd1));
    stNow.issue = cpuValid && allowed;
    stNow.write = cpuValid && cpuWrite;
    stNow.fault = cpuValid && !allowed;
    stNow.win   = win;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stReg <= '0;
    else       stReg <= stNow;
  end

endmodule

// File: rtl/hbw_datapath.sv
module hbw_datapath
  import hbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] MEM_BASE = 32'hC000_0000,
  parameter int unsigned DEV_LO = 11,
  parameter int unsigned DEV_CNT = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stNow,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [2:0]            cpuSize,
  input  logic [DATA_W-1:0]     cpuWdata,
  input  logic [ADDR_W-1:0]     ioPort,
  output logic [ADDR_W-1:0]     bkAddr,
  output logic [2*DATA_W/8-1:0] bkLanes,
  output logic [2*DATA_W-1:0]   bkData
);

  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned LANES = 2 * BYTES;
  localparam int unsigned OFF_W = $clog2(BYTES);
  localparam int unsigned DEV_W = $clog2(DEV_CNT + 1);

  logic [BYTES-1:0]  byteMask;
  logic [DATA_W-1:0] wdataMasked;
  logic [LANES-1:0]  lanesD;
  logic [2*DATA_W-1:0] dataD;
  logic [DEV_W-1:0]  devIdx;
  logic [ADDR_W-1:0] addrD;
  logic [OFF_W-1:0]  laneOff;

  always_comb begin
    laneOff = cpuAddr[OFF_W-1:0];
    for (int b = 0; b < BYTES; b++) begin
      byteMask[b] = (b < int'(cpuSize));
      wdataMasked[8*b +: 8] = byteMask[b] ? cpuWdata[8*b +: 8] : 8'h00;
    end
    lanesD = LANES'(byteMask) << laneOff;
    dataD  = stNow.write ? ((2*DATA_W)'(wdataMasked) << {laneOff, 3'b000}) : '0;
  end

  always_comb begin
    devIdx = DEV_W'(DEV_CNT);
    for (int k = DEV_CNT - 1; k >= 0; k--) begin
      if (cpuAddr[DEV_LO + k]) devIdx = DEV_W'(k);
    end
  end

  always_comb begin
    case (stNow.win)
      WIN_CFG:             addrD = ADDR_W'({devIdx, cpuAddr[DEV_LO-1:0]});
      WIN_IO, WIN_CFGPORT: addrD = IO_BASE + ioPort;
      WIN_MEM:             addrD = cpuAddr - MEM_BASE;
      default:             addrD = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bkAddr  <= '0;
      bkLanes <= '0;
      bkData  <= '0;
    end else if (stNow.issue && !stNow.fault) begin
      bkAddr  <= addrD;
      bkLanes <= lanesD;
      bkData  <= dataD;
    end
  end

endmodule

// File: rtl/host_window_decoder.sv
module host_window_decoder
  import hbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuValid,
  input  logic                  cpuWrite,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [2:0]            cpuSize,
  input  logic [DATA_W-1:0]     cpuWdata,
  input  logic                  sparseMode,
  output logic                  bkValid,
  output logic                  bkWrite,
  output logic                  bkError,
  output logic [2:0]            bkWindow,
  output logic [ADDR_W-1:0]     bkAddr,
  output logic [2*DATA_W/8-1:0] bkLanes,
  output logic [2*DATA_W-1:0]   bkData
);

  logic [ADDR_W-1:0] ioPort;
  strobe_t stNow;
  strobe_t stReg;

  hbw_io_map #(.ADDR_W(ADDR_W)) i_ioMap (
    .clk(clk), .rstN(rstN), .sparseMode(sparseMode),
    .cpuAddr(cpuAddr), .ioPort(ioPort)
  );

  hbw_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuSize(cpuSize), .ioPort(ioPort),
    .stNow(stNow), .stReg(stReg)
  );

  hbw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .stNow(stNow), .cpuAddr(cpuAddr),
    .cpuSize(cpuSize), .cpuWdata(cpuWdata), .ioPort(ioPort),
    .bkAddr(bkAddr), .bkLanes(bkLanes), .bkData(bkData)
  );

  assign bkValid  = stReg.issue;
  assign bkWrite  = stReg.write;
  assign bkError  = stReg.fault;
  assign bkWindow = stReg.win;

endmodule

// File: rtl/hbw_checker.sv
module hbw_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cpuValid,
  input logic [1:0]  cpuTop,
  input logic        bkValid,
  input logic        bkError,
  input logic [2:0]  bkWindow,
  input logic [31:0] bkAddr,
  input logic [7:0]  bkLanes
);

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    bkError |-> !bkValid); // R9

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |=> (bkValid || bkError)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cpuValid |=> !(bkValid || bkError)); // R10

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    bkValid |-> ($countones(bkLanes) == 1 || $countones(bkLanes) == 2 ||
                 $countones(bkLanes) == 4)); // R8

  AST_CFG_DEV_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (bkValid && bkWindow == 3'd2) |-> ((bkAddr >> 11) <= 32'd11)); // R2

  AST_IO_REBASE: assert property (@(posedge clk) disable iff (!rstN)
    (bkValid && (bkWindow == 3'd1 || bkWindow == 3'd3)) |-> ((bkAddr >> 20) == 32'h800)); // R6

  AST_MEM_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (bkValid && bkWindow == 3'd5) |-> ($past(cpuTop) == 2'b11)); // R11

endmodule

bind host_window_decoder hbw_checker i_hbwChecker (
  .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuTop(cpuAddr[31:30]),
  .bkValid(bkValid), .bkError(bkError), .bkWindow(bkWindow),
  .bkAddr(bkAddr), .bkLanes(bkLanes)
);

// File: tb/test_host_window_decoder.sv
module test_host_window_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0;
  logic        cpuWrite = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [2:0]  cpuSize = 3'd0;
  logic [31:0] cpuWdata = '0;
  logic        sparseMode = 1'b0;
  logic        bkValid, bkWrite, bkError;
  logic [2:0]  bkWindow;
  logic [31:0] bkAddr;
  logic [7:0]  bkLanes;
  logic [63:0] bkData;

  int checks = 0;
  int fails = 0;
  logic prevMode = 1'b0;

  typedef struct {
    logic        idle;
    logic        err;
    logic        wr;
    logic [2:0]  win;
    logic [31:0] addr;
    logic [7:0]  lanes;
    logic [63:0] data;
    string       tag;
  } item_t;

  item_t q[$];

  host_window_decoder i_host_window_decoder (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuSize(cpuSize), .cpuWdata(cpuWdata),
    .sparseMode(sparseMode), .bkValid(bkValid), .bkWrite(bkWrite),
    .bkError(bkError), .bkWindow(bkWindow), .bkAddr(bkAddr),
    .bkLanes(bkLanes), .bkData(bkData)
  );

  always #2 clk = ~clk;

  function automatic item_t model(input logic [31:0] a, input logic [2:0] sz,
                                  input logic wr, input logic [31:0] wd,
                                  input logic md, input string tag);
    item_t e;
    logic [31:0] off, port;
    int dev, lo;
    e.idle = 1'b0; e.err = 1'b0; e.wr = wr; e.win = 3'd0;
    e.addr = '0; e.lanes = '0; e.data = '0; e.tag = tag;
    port = '0;
    if (a == 32'hBFFF_FFF0) e.win = 3'd4;
    else if (a >= 32'h8080_0000 && a <= 32'h80BF_FFFF) e.win = 3'd2;
    else if (a >= 32'hC000_0000) e.win = 3'd5;
    else if (a >= 32'h8000_0000) begin
      off = a - 32'h8000_0000;
      port = md ? (((off & 32'h07FF_F000) >> 7) | (off & 32'h1F)) : (off & 32'hFFFF);
      e.win = (port >= 32'hCF8 && port <= 32'hCFF) ? 3'd3 : 3'd1;
    end
    if (!(sz == 3'd1 || sz == 3'd2 || sz == 3'd4) || e.win == 3'd0 ||
        (e.win == 3'd4 && sz != 3'd1)) begin
      e.err = 1'b1;
      return e;
    end
    case (e.win)
      3'd2: begin
        dev = 11;
        for (int k = 0; k < 11; k++) begin
          if (a[11+k]) begin dev = k; break; end
        end
        e.addr = (32'(dev) << 11) | (a & 32'h7FF);
      end
      3'd1, 3'd3: e.addr = 32'h8000_0000 + port;
      3'd5: e.addr = a - 32'hC000_0000;
      default: e.addr = '0;
    endcase
    lo = int'(a[1:0]);
    for (int b = 0; b < int'(sz); b++) begin
      e.lanes[lo+b] = 1'b1;
      if (wr) e.data[8*(lo+b) +: 8] = wd[8*b +: 8];
    end
    return e;
  endfunction

  task automatic access(input logic [31:0] a, input logic [2:0] sz, input logic wr,
                        input logic [31:0] wd, input logic md, input string tag);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuSize = sz;
    cpuWdata = wd; sparseMode = md;
    q.push_back(model(a, sz, wr, wd, prevMode, tag));
    prevMode = md;
  endtask

  task automatic idle(input logic md, input string tag);
    item_t e;
    @(negedge clk);
    cpuValid = 1'b0; cpuWrite = 1'b0; sparseMode = md;
    e.idle = 1'b1; e.err = 1'b0; e.wr = 1'b0; e.win = 3'd0;
    e.addr = '0; e.lanes = '0; e.data = '0; e.tag = tag;
    q.push_back(e);
    prevMode = md;
  endtask

  always begin
    item_t it;
    logic ok;
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (it.idle) ok = !bkValid && !bkError;
      else if (it.err) ok = bkError && !bkValid;
      else ok = bkValid && !bkError && bkWrite == it.wr && bkWindow == it.win &&
                bkAddr == it.addr && bkLanes == it.lanes && bkData == it.data;
      if (!ok) begin
        fails++;
        $display("FAIL %s: got v=%0b e=%0b w=%0b win=%0d addr=%h lanes=%h data=%h, expected idle=%0b e=%0b w=%0b win=%0d addr=%h lanes=%h data=%h",
                 it.tag, bkValid, bkError, bkWrite, bkWindow, bkAddr, bkLanes, bkData,
                 it.idle, it.err, it.wr, it.win, it.addr, it.lanes, it.data);
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checks++;
    if (bkValid || bkError) begin
      fails++;
      $display("FAIL R10 reset: got v=%0b e=%0b, expected 0 0", bkValid, bkError);
    end
    idle(1'b0, "R10 idle");
    // R2: single, multiple, top device-select bits
    access(32'h8080_0800, 3'd4, 1'b1, 32'h1122_3344, 1'b0, "R2 dev0");
    access(32'h8080_3004, 3'd4, 1'b0, 32'h0, 1'b0, "R2 lowest of two");
    access(32'h80A0_0010, 3'd1, 1'b1, 32'hA5, 1'b0, "R2 dev10");
    access(32'h8080_0123, 3'd2, 1'b0, 32'h0, 1'b0, "R3 no select bit");
    // R4 contiguous I/O and R6 config port edges
    access(32'h8001_2345, 3'd1, 1'b1, 32'h5A, 1'b0, "R4 contiguous");
    access(32'h8000_0CF7, 3'd1, 1'b0, 32'h0, 1'b0, "R6 below port pair");
    access(32'h8000_0CF8, 3'd4, 1'b1, 32'h8000_0000, 1'b0, "R6 index port");
    access(32'h8000_0CFC, 3'd4, 1'b0, 32'h0, 1'b0, "R6 data port");
    // R7: mode switch in the same cycle still uses old mode
    access(32'h8012_3013, 3'd2, 1'b1, 32'hBEEF, 1'b1, "R7 old mode");
    access(32'h8012_3013, 3'd2, 1'b1, 32'hBEEF, 1'b1, "R5 sparse");
    access(32'h8000_67F9, 3'd1, 1'b0, 32'h0, 1'b0, "R7 back to old sparse");
    access(32'h8000_67F9, 3'd1, 1'b0, 32'h0, 1'b0, "R4 contiguous again");
    // R8 lanes, R11 memory and intack
    access(32'hC000_0003, 3'd2, 1'b1, 32'hAABB_CCDD, 1'b0, "R8 unaligned half");
    access(32'hC123_4566, 3'd4, 1'b1, 32'h0102_0304, 1'b0, "R8 unaligned word");
    access(32'hC123_4567, 3'd4, 1'b0, 32'h0, 1'b0, "R11 memory read");
    access(32'hBFFF_FFF0, 3'd1, 1'b0, 32'h0, 1'b0, "R11 intack");
    access(32'hF000_0000, 3'd2, 1'b1, 32'h0000_1234, 1'b0, "R1 memory top");
    // R9 refusals
    access(32'hBFFF_FFF0, 3'd2, 1'b0, 32'h0, 1'b0, "R9 wide intack");
    access(32'hC000_0000, 3'd3, 1'b1, 32'h0, 1'b0, "R9 size 3");
    access(32'h1000_0000, 3'd4, 1'b0, 32'h0, 1'b0, "R9 unmapped");
    access(32'h7FFF_FFFF, 3'd1, 1'b0, 32'h0, 1'b0, "R1 just below io");
    idle(1'b0, "R10 quiet after error");
    idle(1'b0, "R10 quiet");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule